// File: doc/BRIEF.md
# Firmware Glue Peripheral

This block is a small memory-mapped peripheral shared by the processors of a multiprocessor system. Through one register port, firmware can stop the system with an exit code, find out which processor it is running on, learn how many processors are configured, and raise or drop the external interrupt line of any processor. It also holds a one-character console receive buffer and a one-character console transmit buffer, each with its own status byte.

Each bus access lasts one cycle. The requester sets a select strobe, a write flag, an address, a size code, a 32-bit write word and its own processor number. Read data is registered and shows on `bus_rdata` in the cycle after the read. The console connects through a byte stream with valid/ready in each direction. A byte is taken from the receive stream only when software reads the receive status register.

Top module: `fw_glue_top`

## Requirements
- R1: Only address bits [4:0] are decoded, so an address whose low five bits match a register offset reaches that register.
- R2: A write to offset 0x00 gives a one-cycle `halt_pulse` in the cycle after the write, with `exit_code` equal to write byte 0 (`bus_wdata[7:0]`).
- R3: A read of offset 0x04 returns `bus_cpu`, the number of the requesting processor.
- R4: A read of offset 0x0A returns NUM_CPUS.
- R5: A write to offset 0x08 selects the interrupt port with byte 0 (`bus_wdata[7:0]`). The level is byte 1 (`bus_wdata[15:8]`) when `bus_size` is 1 (two bytes) or 2 (four bytes), and 0 when `bus_size` is 0 (one byte). `irq_level[port]` is set when the level is nonzero and cleared when it is zero, from the cycle after the write. A port number of NUM_CPUS or more changes no line.
- R6: A read places an 8-bit value in `bus_rdata[7:0]`, with bits [31:8] zero, in the cycle after the read. The value holds until the next read. Offsets not listed here, and the write-only offsets 0x00 and 0x08, read as zero.
- R7: A read of offset 0x14 raises `cin_ready` in that same cycle, and only then. If `cin_valid` is high, the byte is latched as the receive data and the receive status becomes 1. Otherwise both become 0. The read returns the new status.
- R8: A write to offset 0x18 while no byte is pending latches byte 0 as the transmit data, sets the transmit status to 1, and raises `cout_valid` with that byte on `cout_data`. The byte stays presented until `cout_ready` is high at a clock edge. Writes to 0x18 while a byte is pending are dropped. A read of 0x18 returns the last accepted byte.
- R9: Software writes to offsets 0x10 (receive data), 0x14 (receive status) and 0x1A (transmit status) store byte 0 as is. Reads of 0x10 and 0x1A return the stored byte.
- R10: After reset the transmit status is 1, the receive status is 0, both data bytes are 0, all interrupt lines are low, and `halt_pulse` and `cout_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address; only bits [4:0] are decoded |
| bus_size | input | 2 | Write size code: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes |
| bus_wdata | input | 32 | Write data; byte 0 in bits [7:0] |
| bus_cpu | input | CPU_W | Number of the requesting processor |
| bus_rdata | output | 32 | Registered read data |
| halt_pulse | output | 1 | One-cycle halt request |
| exit_code | output | 8 | Exit code captured on a halt write |
| irq_level | output | NUM_CPUS | Level interrupt line for each processor |
| cin_valid | input | 1 | Receive stream byte available |
| cin_data | input | 8 | Receive stream byte |
| cin_ready | output | 1 | Receive byte taken this cycle |
| cout_valid | output | 1 | Transmit byte pending |
| cout_data | output | 8 | Transmit byte |
| cout_ready | input | 1 | Transmit byte accepted this cycle |

## Verification
A corrupted interrupt register shows at once on `irq_level`, one cycle after the write that should have set it. The bench therefore keeps a model of every line and compares it after each write in a sweep over ports and levels. Faults in the console buffers stay hidden until a read or a stream handshake, so every console step is followed by a read-back or a check of the stream handshake signals. A sweep over twice the decoded address range catches decode and aliasing errors one cycle after each read.

// File: rtl/fw_glue_pkg.sv
package fw_glue_pkg;
  localparam logic [4:0] OFS_EXIT     = 5'h00;
  localparam logic [4:0] OFS_CPUID    = 5'h04;
  localparam logic [4:0] OFS_IRQ      = 5'h08;
  localparam logic [4:0] OFS_COUNT    = 5'h0A;
  localparam logic [4:0] OFS_RX_DATA  = 5'h10;
  localparam logic [4:0] OFS_RX_STAT  = 5'h14;
  localparam logic [4:0] OFS_TX_DATA  = 5'h18;
  localparam logic [4:0] OFS_TX_STAT  = 5'h1A;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_EXIT, SEL_CPUID, SEL_IRQ, SEL_COUNT,
    SEL_RX_DATA, SEL_RX_STAT, SEL_TX_DATA, SEL_TX_STAT
  } regsel_e;
endpackage

// File: rtl/fw_glue_decode.sv
module fw_glue_decode
  import fw_glue_pkg::*;
(
  input  logic [4:0] ofs,
  output regsel_e    sel
);
  always_comb begin
    case (ofs)
      OFS_EXIT:    sel = SEL_EXIT;
      OFS_CPUID:   sel = SEL_CPUID;
      OFS_IRQ:     sel = SEL_IRQ;
      OFS_COUNT:   sel = SEL_COUNT;
      OFS_RX_DATA: sel = SEL_RX_DATA;
      OFS_RX_STAT: sel = SEL_RX_STAT;
      OFS_TX_DATA: sel = SEL_TX_DATA;
      OFS_TX_STAT: sel = SEL_TX_STAT;
      default:     sel = SEL_NONE;
    endcase
  end
endmodule

// File: rtl/fw_glue_irq_bank.sv
module fw_glue_irq_bank #(
  parameter int NUM_CPUS = 4,
  parameter int PORT_W   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [PORT_W-1:0]   port,
  input  logic [7:0]          level,
  output logic [NUM_CPUS-1:0] irq_level
);
  logic [NUM_CPUS-1:0] line_q, line_d, line_en;

  for (genvar n = 0; n < NUM_CPUS; n++) begin : g_line
    always_comb begin
      line_en[n] = wr_en && (port == PORT_W'(n));
      line_d[n]  = (level != 8'd0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          line_q[n] <= 1'b0;
      else if (line_en[n]) line_q[n] <= line_d[n];
    end
  end

  assign irq_level = line_q;

  // R5
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(irq_level));
endmodule

// File: rtl/fw_glue_console.sv
module fw_glue_console (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_stat_rd,
  input  logic       rx_data_wr,
  input  logic       rx_stat_wr,
  input  logic       tx_data_wr,
  input  logic       tx_stat_wr,
  input  logic [7:0] wbyte,
  input  logic       cin_valid,
  input  logic [7:0] cin_data,
  output logic       cin_ready,
  output logic       cout_valid,
  output logic [7:0] cout_data,
  input  logic       cout_ready,
  output logic [7:0] rx_data,
  output logic [7:0] rx_stat,
  output logic [7:0] tx_data,
  output logic [7:0] tx_stat
);
  logic [7:0] rx_data_q, rx_data_d, rx_stat_q, rx_stat_d;
  logic [7:0] tx_data_q, tx_data_d, tx_stat_q, tx_stat_d;
  logic       pend_q, pend_d, tx_take;

  always_comb begin
    rx_data_d = rx_data_q;
    rx_stat_d = rx_stat_q;
    if (rx_stat_rd) begin
      rx_data_d = cin_valid ? cin_data : 8'd0;
      rx_stat_d = cin_valid ? 8'd1 : 8'd0;
    end else begin
      if (rx_data_wr) rx_data_d = wbyte;
      if (rx_stat_wr) rx_stat_d = wbyte;
    end
  end

  always_comb begin
    tx_take   = tx_data_wr && !pend_q;
    tx_data_d = tx_take ? wbyte : tx_data_q;
    tx_stat_d = tx_stat_q;
    if (tx_take)         tx_stat_d = 8'd1;
    else if (tx_stat_wr) tx_stat_d = wbyte;
    pend_d = pend_q;
    if (tx_take)                  pend_d = 1'b1;
    else if (pend_q && cout_ready) pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data_q <= 8'd0;
      rx_stat_q <= 8'd0;
      tx_data_q <= 8'd0;
      tx_stat_q <= 8'd1;
      pend_q    <= 1'b0;
    end else begin
      rx_data_q <= rx_data_d;
      rx_stat_q <= rx_stat_d;
      tx_data_q <= tx_data_d;
      tx_stat_q <= tx_stat_d;
      pend_q    <= pend_d;
    end
  end

  assign cin_ready  = rx_stat_rd;
  assign cout_valid = pend_q;
  assign cout_data  = tx_data_q;
  assign rx_data    = rx_data_q;
  assign rx_stat    = rx_stat_q;
  assign tx_data    = tx_data_q;
  assign tx_stat    = tx_stat_q;

  // R7
  rx_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_stat_rd && cin_valid) |=> (rx_stat == 8'd1 && rx_data == $past(cin_data)));
  // R8
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cout_valid && !cout_ready) |=> (cout_valid && $stable(cout_data)));
endmodule

// File: rtl/fw_glue_top.sv
module fw_glue_top
  import fw_glue_pkg::*;
#(
  parameter int NUM_CPUS = 4,
  parameter int ADDR_W   = 16,
  localparam int CPU_W   = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_sel,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [1:0]          bus_size,
  input  logic [31:0]         bus_wdata,
  input  logic [CPU_W-1:0]    bus_cpu,
  output logic [31:0]         bus_rdata,
  output logic                halt_pulse,
  output logic [7:0]          exit_code,
  output logic [NUM_CPUS-1:0] irq_level,
  input  logic                cin_valid,
  input  logic [7:0]          cin_data,
  output logic                cin_ready,
  output logic                cout_valid,
  output logic [7:0]          cout_data,
  input  logic                cout_ready
);
  logic [1:0] rst_sync_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  regsel_e    sel;
  logic       wr_acc, rd_acc;
  logic [7:0] byte0, level_eff;
  logic [7:0] rx_data, rx_stat, tx_data, tx_stat;

  fw_glue_decode u_decode (.ofs(bus_addr[4:0]), .sel(sel));

  always_comb begin
    wr_acc    = bus_sel && bus_wr;
    rd_acc    = bus_sel && !bus_wr;
    byte0     = bus_wdata[7:0];
    level_eff = (bus_size != 2'd0) ? bus_wdata[15:8] : 8'd0;
  end

  fw_glue_irq_bank #(.NUM_CPUS(NUM_CPUS), .PORT_W(8)) u_irq (
    .clk(clk), .rst_n(rst_i_n),
    .wr_en(wr_acc && sel == SEL_IRQ),
    .port(byte0), .level(level_eff),
    .irq_level(irq_level)
  );

  fw_glue_console u_con (
    .clk(clk), .rst_n(rst_i_n),
    .rx_stat_rd(rd_acc && sel == SEL_RX_STAT),
    .rx_data_wr(wr_acc && sel == SEL_RX_DATA),
    .rx_stat_wr(wr_acc && sel == SEL_RX_STAT),
    .tx_data_wr(wr_acc && sel == SEL_TX_DATA),
    .tx_stat_wr(wr_acc && sel == SEL_TX_STAT),
    .wbyte(byte0),
    .cin_valid(cin_valid), .cin_data(cin_data), .cin_ready(cin_ready),
    .cout_valid(cout_valid), .cout_data(cout_data), .cout_ready(cout_ready),
    .rx_data(rx_data), .rx_stat(rx_stat), .tx_data(tx_data), .tx_stat(tx_stat)
  );

  logic       halt_q, halt_d, exit_en;
  logic [7:0] exit_q;
  logic [7:0] rbyte_q, rbyte_d;

  always_comb begin
    halt_d  = wr_acc && sel == SEL_EXIT;
    exit_en = halt_d;
    case (sel)
      SEL_CPUID:   rbyte_d = 8'(bus_cpu);
      SEL_COUNT:   rbyte_d = 8'(NUM_CPUS);
      SEL_RX_DATA: rbyte_d = rx_data;
      SEL_RX_STAT: rbyte_d = cin_valid ? 8'd1 : 8'd0;
      SEL_TX_DATA: rbyte_d = tx_data;
      SEL_TX_STAT: rbyte_d = tx_stat;
      default:     rbyte_d = 8'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      halt_q  <= 1'b0;
      exit_q  <= 8'd0;
      rbyte_q <= 8'd0;
    end else begin
      halt_q <= halt_d;
      if (exit_en) exit_q  <= byte0;
      if (rd_acc)  rbyte_q <= rbyte_d;
    end
  end

  assign halt_pulse = halt_q;
  assign exit_code  = exit_q;
  assign bus_rdata  = {24'd0, rbyte_q};

  // R2
  halt_src_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    halt_pulse |-> $past(bus_sel && bus_wr && bus_addr[4:0] == OFS_EXIT));
  // R7
  rx_ready_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    cin_ready |-> (bus_sel && !bus_wr));
endmodule

// File: tb/fw_glue_top_test.sv
module fw_glue_top_test;
  localparam int CLK_PERIOD = 10;
  localparam int NCPU = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [1:0]  bus_size = '0;
  logic [31:0] bus_wdata = '0;
  logic [1:0]  bus_cpu = '0;
  logic [31:0] bus_rdata;
  logic        halt_pulse;
  logic [7:0]  exit_code;
  logic [NCPU-1:0] irq_level;
  logic        cin_valid = 1'b0;
  logic [7:0]  cin_data = '0;
  logic        cin_ready, cout_valid;
  logic [7:0]  cout_data;
  logic        cout_ready = 1'b0;

  int tests = 0, fails = 0, cyc = 0;

  fw_glue_top #(.NUM_CPUS(NCPU), .ADDR_W(16)) uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      fails++; tests++;
      $display("FAIL watchdog: actual %0d cycles, expected fewer", cyc);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [15:0] a, logic [1:0] sz, logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_size = sz; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(logic [15:0] a, logic [1:0] cpu, output logic [31:0] v);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a; bus_cpu = cpu;
    @(negedge clk);
    bus_sel = 0;
    v = bus_rdata;
  endtask

  initial begin
    logic [31:0] v;
    logic [NCPU-1:0] irq_m;
    logic [7:0] rxd_m, txd_m, txs_m, e;

    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R10 reset state
    check("R10 irq", irq_level, 0);
    check("R10 halt", halt_pulse, 0);
    check("R10 cout_valid", cout_valid, 0);
    rd(16'h1A, 0, v); check("R10 tx status", v, 1);
    rd(16'h18, 0, v); check("R10 tx data", v, 0);
    rd(16'h10, 0, v); check("R10 rx data", v, 0);
    rd(16'h14, 0, v); check("R10 rx status", v, 0);

    // R3 processor id for every requester
    for (int c = 0; c < NCPU; c++) begin
      rd(16'h04, 2'(c), v); check("R3 cpu id", v, c);
    end
    // R4
    rd(16'h0A, 3, v); check("R4 count", v, NCPU);

    // R2 halt
    wr(16'h00, 2'd2, 32'hFFEE_DD5C);
    check("R2 halt pulse", halt_pulse, 1);
    check("R2 exit code", exit_code, 8'h5C);
    @(negedge clk);
    check("R2 pulse one cycle", halt_pulse, 0);

    // R5 interrupt sweep
    irq_m = '0;
    for (int p = 0; p < 8; p++)
      for (int sz = 0; sz < 3; sz++)
        for (int lv = 0; lv < 2; lv++) begin
          logic [7:0] lvb;
          lvb = lv ? 8'h03 : 8'h00;
          wr(16'h08, 2'(sz), {16'hA5A5, lvb, 8'(p)});
          if (p < NCPU) irq_m[p] = (sz != 0) && (lvb != 0);
          check("R5 irq sweep", irq_level, irq_m);
        end
    wr(16'h08, 2'd1, 32'h0000_0102);
    irq_m[2] = 1'b1;
    check("R5 port 2 example", irq_level, irq_m);
    wr(16'h08, 2'd0, 32'h0000_FF02);
    irq_m[2] = 1'b0;
    check("R5 one-byte write clears", irq_level, irq_m);

    // R7 receive sampling
    @(negedge clk);
    cin_valid = 1; cin_data = 8'h5A;
    #1 check("R7 no ready when idle", cin_ready, 0);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = 16'h14;
    #1 check("R7 ready during status read", cin_ready, 1);
    @(negedge clk);
    bus_sel = 0; cin_valid = 0;
    check("R7 status read returns 1", bus_rdata, 1);
    rd(16'h10, 0, v); check("R7 latched byte", v, 8'h5A);
    rd(16'h14, 0, v); check("R7 empty status", v, 0);
    rd(16'h10, 0, v); check("R7 data cleared", v, 0);

    // R9 software writes
    wr(16'h10, 2'd0, 32'h77);
    rd(16'h10, 0, v); check("R9 rx data write", v, 8'h77);
    wr(16'h1A, 2'd0, 32'h00);
    rd(16'h1A, 0, v); check("R9 tx status write", v, 0);

    // R8 transmit
    wr(16'h18, 2'd0, 32'h41);
    check("R8 cout_valid", cout_valid, 1);
    check("R8 cout_data", cout_data, 8'h41);
    rd(16'h1A, 0, v); check("R8 tx status set", v, 1);
    wr(16'h18, 2'd0, 32'h42);
    check("R8 busy write dropped", cout_data, 8'h41);
    rd(16'h18, 0, v); check("R8 readback", v, 8'h41);
    @(negedge clk); cout_ready = 1;
    @(negedge clk); cout_ready = 0;
    check("R8 released", cout_valid, 0);
    wr(16'h18, 2'd0, 32'h43);
    check("R8 next byte", cout_data, 8'h43);
    @(negedge clk); cout_ready = 1;
    @(negedge clk); cout_ready = 0;

    // R1 R6 address sweep with computed expectations
    wr(16'h10, 2'd0, 32'h33);
    wr(16'h1A, 2'd0, 32'h09);
    rxd_m = 8'h33; txd_m = 8'h43; txs_m = 8'h09;
    for (int a = 0; a < 64; a++) begin
      int o;
      o = a & 31;
      case (o)
        4:  e = 8'(a % NCPU);
        10: e = NCPU;
        16: e = rxd_m;
        20: begin e = 0; rxd_m = 0; end
        24: e = txd_m;
        26: e = txs_m;
        default: e = 0;
      endcase
      rd(16'(a), 2'(a % NCPU), v);
      check("R1 R6 address sweep", v, {24'd0, e});
    end
    // R6 hold until next read
    rd(16'h0A, 0, v);
    repeat (3) @(negedge clk);
    check("R6 read data held", bus_rdata, NCPU);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule